// File: doc/BRIEF.md
# Control Endpoint Handshake and Flag Controller

This block decides the handshake for every packet on a device-side control endpoint and keeps the endpoint's firmware-visible interrupt flags. A protocol engine hands it decoded events, one per cycle: a received SETUP packet (with the data-direction bit of its request), a received OUT data packet, and an IN token. Firmware hands it single-cycle clear strobes for each flag, plus the byte count of the IN packet it has loaded. The block answers each event with ACK, NAK or "send data", and reports whether the shared bank is held.

A SETUP packet is always accepted. It raises its own flag, never the OUT flag, and it cancels whatever data or status stage was under way. OUT data is accepted only while the bank is free. Firmware launches an IN packet by clearing the IN-ready flag. During a control write, an IN token that finds no packet loaded is refused. That refusal raises a flag telling firmware the host has moved on to the status stage, where firmware then loads a zero-length packet. The FIFO-control bit has no meaning here and reads as zero.

Top module: `ctrl_ep_hs`

## Requirements
- R1: Every SETUP event is answered with hs_valid=1 and hs_code=1 (ACK) one cycle later, whatever the flags or bank state.
- R2: A SETUP event sets flag_setup and leaves flag_out at 0 in the following cycle.
- R3: flag_setup stays at 1 until a fw_clr_setup strobe. That strobe clears it, frees the bank and sets flag_inrdy one cycle later.
- R4: An OUT event while flag_setup and flag_out are both 0 is answered with ACK and sets flag_out. A fw_clr_out strobe clears flag_out.
- R5: A fw_clr_inrdy strobe while flag_inrdy=1 clears flag_inrdy and loads a packet whose length is fw_byte_cnt clamped to MAX_PKT. The next IN token is answered with hs_code=2 (DATA) and hs_len equal to that length, and flag_inrdy is set again. A fw_clr_inrdy strobe while flag_inrdy=0 has no effect.
- R6: An OUT event while flag_setup or flag_out is 1 is answered with hs_code=0 (NAK) and leaves both flags unchanged.
- R7: An IN token with no packet loaded is answered with NAK. If the last SETUP had setup_dir_in=0 (control write), this also sets flag_nakin, which holds until fw_clr_nakin. After a SETUP with setup_dir_in=1, it does not set flag_nakin.
- R8: A SETUP event clears flag_inrdy, flag_nakin, flag_out and any loaded IN packet.
- R9: A loaded IN packet of length zero is answered with DATA, hs_len=0 and hs_zlp=1. hs_zlp is 0 for any other response.
- R10: fifo_ctl reads 0 at all times.
- R11: When events coincide, SETUP takes priority over OUT, and OUT over IN. The lower-priority events get no response and change no state.
- R12: All handshake outputs are registered. They appear one cycle after the event and are hs_valid=0, hs_code=0, hs_len=0, hs_zlp=0 in cycles that follow no event. After reset all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tok_setup | input | 1 | SETUP packet received this cycle |
| setup_dir_in | input | 1 | Request direction with tok_setup: 1 device-to-host, 0 host-to-device |
| tok_out | input | 1 | OUT data packet received this cycle |
| tok_in | input | 1 | IN token received this cycle |
| fw_clr_setup | input | 1 | Firmware clears flag_setup |
| fw_clr_out | input | 1 | Firmware clears flag_out |
| fw_clr_inrdy | input | 1 | Firmware clears flag_inrdy, launching the IN packet |
| fw_clr_nakin | input | 1 | Firmware clears flag_nakin |
| fw_byte_cnt | input | LEN_W | Byte count of the IN packet, sampled with fw_clr_inrdy |
| hs_valid | output | 1 | A response is presented this cycle |
| hs_code | output | 2 | 0 NAK, 1 ACK, 2 DATA |
| hs_zlp | output | 1 | DATA response carries zero bytes |
| hs_len | output | LEN_W | Byte length of a DATA response |
| flag_setup | output | 1 | SETUP received, awaiting firmware |
| flag_out | output | 1 | OUT data received, awaiting firmware |
| flag_inrdy | output | 1 | Bank ready for firmware to load an IN packet |
| flag_nakin | output | 1 | IN token NAKed during a control write |
| bank_busy | output | 1 | Bank held by a SETUP, OUT data or a loaded IN packet |
| fifo_ctl | output | 1 | FIFO-control bit, constant zero |

## Verification
On every cycle, the assertions check the local consequences of an event. A SETUP must be ACKed and leave only its own flag set, with the IN side cleared. An OUT that arrives while the bank is held must be NAKed. Loading a packet must drop the IN-ready flag. An unmet IN token in a control write must raise the NAKed-IN flag. Only the bench's scenarios can show the full sequences: a control write ending with a zero-length status packet, a control read whose refused IN tokens stay silent, length clamping, coinciding events, and a SETUP arriving in the middle of a stage.

// File: rtl/ctrl_ep_pkg.sv
package ctrl_ep_pkg;
  typedef enum logic [1:0] {
    HS_NAK  = 2'd0,
    HS_ACK  = 2'd1,
    HS_DATA = 2'd2
  } hs_code_e;
endpackage

// File: rtl/ctrl_ep_rx_flags.sv
module ctrl_ep_rx_flags (
  input  logic clk,
  input  logic rst,
  input  logic ev_setup,
  input  logic ev_out,
  input  logic clr_setup,
  input  logic clr_out,
  output logic fl_setup,
  output logic fl_out,
  output logic hold
);
  logic out_take;

  assign out_take = ev_out && !fl_setup && !fl_out;
  assign hold     = fl_setup || fl_out;

  always_ff @(posedge clk) begin
    if (rst) begin
      fl_setup <= 1'b0;
      fl_out   <= 1'b0;
    end else if (ev_setup) begin
      fl_setup <= 1'b1;
      fl_out   <= 1'b0;
    end else begin
      if (clr_setup) fl_setup <= 1'b0;
      if (out_take)      fl_out <= 1'b1;
      else if (clr_out)  fl_out <= 1'b0;
    end
  end

  a_r2_setup_own_flag: assert property (@(posedge clk) disable iff (rst)
    ev_setup |=> (fl_setup && !fl_out));

  a_r6_held_flags_keep: assert property (@(posedge clk) disable iff (rst)
    (ev_out && hold && !ev_setup && !clr_setup && !clr_out) |=>
      ($stable(fl_setup) && $stable(fl_out)));
endmodule

// File: rtl/ctrl_ep_tx_bank.sv
module ctrl_ep_tx_bank #(
  parameter int MAX_PKT = 64,
  parameter int LEN_W   = $clog2(MAX_PKT + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ev_setup,
  input  logic             dir_in,
  input  logic             ev_in,
  input  logic             release_setup,
  input  logic             clr_inrdy,
  input  logic             clr_nakin,
  input  logic [LEN_W-1:0] byte_cnt,
  output logic             fl_inrdy,
  output logic             fl_nakin,
  output logic             armed,
  output logic [LEN_W-1:0] arm_len
);
  localparam logic [LEN_W-1:0] LenCap = LEN_W'(MAX_PKT);

  logic             wr_xfer;
  logic             arm_now;
  logic [LEN_W-1:0] cnt_cap;

  assign arm_now = clr_inrdy && fl_inrdy;
  assign cnt_cap = (byte_cnt > LenCap) ? LenCap : byte_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      fl_inrdy <= 1'b0;
      fl_nakin <= 1'b0;
      armed    <= 1'b0;
      arm_len  <= '0;
      wr_xfer  <= 1'b0;
    end else if (ev_setup) begin
      fl_inrdy <= 1'b0;
      fl_nakin <= 1'b0;
      armed    <= 1'b0;
      arm_len  <= '0;
      wr_xfer  <= !dir_in;
    end else begin
      if (ev_in && armed) begin
        armed    <= 1'b0;
        fl_inrdy <= 1'b1;
      end else if (arm_now) begin
        armed    <= 1'b1;
        arm_len  <= cnt_cap;
        fl_inrdy <= 1'b0;
      end else if (release_setup) begin
        fl_inrdy <= 1'b1;
      end
      if (ev_in && !armed && wr_xfer) fl_nakin <= 1'b1;
      else if (clr_nakin)             fl_nakin <= 1'b0;
    end
  end

  a_r5_arm_drops_ready: assert property (@(posedge clk) disable iff (rst)
    (arm_now && !ev_setup && !(ev_in && armed)) |=> (armed && !fl_inrdy));

  a_r7_write_nak_flag: assert property (@(posedge clk) disable iff (rst)
    (ev_in && !armed && wr_xfer && !ev_setup) |=> fl_nakin);

  a_r8_setup_aborts: assert property (@(posedge clk) disable iff (rst)
    ev_setup |=> (!fl_inrdy && !armed && !fl_nakin));
endmodule

// File: rtl/ctrl_ep_resp.sv
module ctrl_ep_resp
  import ctrl_ep_pkg::*;
#(
  parameter int LEN_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ev_setup,
  input  logic             ev_out,
  input  logic             ev_in,
  input  logic             hold,
  input  logic             armed,
  input  logic [LEN_W-1:0] arm_len,
  output logic             hs_valid,
  output hs_code_e         hs_code,
  output logic             hs_zlp,
  output logic [LEN_W-1:0] hs_len
);
  always_ff @(posedge clk) begin
    if (rst) begin
      hs_valid <= 1'b0;
      hs_code  <= HS_NAK;
      hs_zlp   <= 1'b0;
      hs_len   <= '0;
    end else begin
      hs_valid <= ev_setup || ev_out || ev_in;
      hs_code  <= HS_NAK;
      hs_zlp   <= 1'b0;
      hs_len   <= '0;
      if (ev_setup) begin
        hs_code <= HS_ACK;
      end else if (ev_out) begin
        hs_code <= hold ? HS_NAK : HS_ACK;
      end else if (ev_in && armed) begin
        hs_code <= HS_DATA;
        hs_len  <= arm_len;
        hs_zlp  <= (arm_len == '0);
      end
    end
  end

  a_r1_setup_acked: assert property (@(posedge clk) disable iff (rst)
    ev_setup |=> (hs_valid && hs_code == HS_ACK));

  a_r6_busy_out_nak: assert property (@(posedge clk) disable iff (rst)
    (ev_out && hold) |=> (hs_code == HS_NAK));

  a_r9_zlp_only_data: assert property (@(posedge clk) disable iff (rst)
    hs_zlp |-> (hs_code == HS_DATA && hs_len == '0));
endmodule

// File: rtl/ctrl_ep_hs.sv
module ctrl_ep_hs #(
  parameter int MAX_PKT = 64,
  parameter int LEN_W   = $clog2(MAX_PKT + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tok_setup,
  input  logic             setup_dir_in,
  input  logic             tok_out,
  input  logic             tok_in,
  input  logic             fw_clr_setup,
  input  logic             fw_clr_out,
  input  logic             fw_clr_inrdy,
  input  logic             fw_clr_nakin,
  input  logic [LEN_W-1:0] fw_byte_cnt,
  output logic             hs_valid,
  output logic [1:0]       hs_code,
  output logic             hs_zlp,
  output logic [LEN_W-1:0] hs_len,
  output logic             flag_setup,
  output logic             flag_out,
  output logic             flag_inrdy,
  output logic             flag_nakin,
  output logic             bank_busy,
  output logic             fifo_ctl
);
  import ctrl_ep_pkg::*;

  logic             ev_setup, ev_out, ev_in;
  logic             hold, armed, release_setup;
  logic [LEN_W-1:0] arm_len;
  hs_code_e         code_q;

  // R11: one event per cycle, SETUP over OUT over IN
  assign ev_setup      = tok_setup;
  assign ev_out        = tok_out && !tok_setup;
  assign ev_in         = tok_in && !tok_setup && !tok_out;
  assign release_setup = fw_clr_setup && flag_setup && !ev_setup;

  ctrl_ep_rx_flags u_rx (
    .clk       (clk),
    .rst       (rst),
    .ev_setup  (ev_setup),
    .ev_out    (ev_out),
    .clr_setup (fw_clr_setup),
    .clr_out   (fw_clr_out),
    .fl_setup  (flag_setup),
    .fl_out    (flag_out),
    .hold      (hold)
  );

  ctrl_ep_tx_bank #(.MAX_PKT(MAX_PKT), .LEN_W(LEN_W)) u_tx (
    .clk           (clk),
    .rst           (rst),
    .ev_setup      (ev_setup),
    .dir_in        (setup_dir_in),
    .ev_in         (ev_in),
    .release_setup (release_setup),
    .clr_inrdy     (fw_clr_inrdy),
    .clr_nakin     (fw_clr_nakin),
    .byte_cnt      (fw_byte_cnt),
    .fl_inrdy      (flag_inrdy),
    .fl_nakin      (flag_nakin),
    .armed         (armed),
    .arm_len       (arm_len)
  );

  ctrl_ep_resp #(.LEN_W(LEN_W)) u_resp (
    .clk      (clk),
    .rst      (rst),
    .ev_setup (ev_setup),
    .ev_out   (ev_out),
    .ev_in    (ev_in),
    .hold     (hold),
    .armed    (armed),
    .arm_len  (arm_len),
    .hs_valid (hs_valid),
    .hs_code  (code_q),
    .hs_zlp   (hs_zlp),
    .hs_len   (hs_len)
  );

  assign hs_code   = code_q;
  assign bank_busy = hold || armed;
  assign fifo_ctl  = 1'b0; // R10

  a_r11_out_beats_in: assert property (@(posedge clk) disable iff (rst)
    (tok_out && tok_in && !tok_setup && hold) |=> (hs_code == 2'd0 && hs_len == '0));
endmodule

// File: tb/ctrl_ep_hs_tb_top.sv
`timescale 1ns/1ps
module ctrl_ep_hs_tb_top;
  localparam int MAX_PKT = 64;
  localparam int LEN_W   = $clog2(MAX_PKT + 1);

  logic clk = 0, rst = 1;
  logic tok_setup = 0, setup_dir_in = 0, tok_out = 0, tok_in = 0;
  logic fw_clr_setup = 0, fw_clr_out = 0, fw_clr_inrdy = 0, fw_clr_nakin = 0;
  logic [LEN_W-1:0] fw_byte_cnt = '0;
  logic hs_valid, hs_zlp, flag_setup, flag_out, flag_inrdy, flag_nakin, bank_busy, fifo_ctl;
  logic [1:0] hs_code;
  logic [LEN_W-1:0] hs_len;

  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  ctrl_ep_hs #(.MAX_PKT(MAX_PKT)) dut_i (.*);

  // behavioural reference model
  int m_fs, m_fo, m_ir, m_nak, m_wr, m_pend, m_plen;
  int m_hv, m_hc, m_zlp, m_hlen;
  always @(posedge clk) begin
    int nfs, nfo, nir, nnak, nwr, npend, nplen, cnt;
    if (rst) begin
      m_fs = 0; m_fo = 0; m_ir = 0; m_nak = 0; m_wr = 0; m_pend = 0; m_plen = 0;
      m_hv = 0; m_hc = 0; m_zlp = 0; m_hlen = 0;
    end else begin
      nfs = m_fs; nfo = m_fo; nir = m_ir; nnak = m_nak; nwr = m_wr; npend = m_pend; nplen = m_plen;
      m_hv = 0; m_hc = 0; m_zlp = 0; m_hlen = 0;
      if (tok_setup) begin
        m_hv = 1; m_hc = 1;
        nfs = 1; nfo = 0; nir = 0; nnak = 0; npend = 0; nplen = 0;
        nwr = setup_dir_in ? 0 : 1;
      end else begin
        if (tok_out) begin
          m_hv = 1;
          if (m_fs == 0 && m_fo == 0) begin m_hc = 1; nfo = 1; end
        end else if (tok_in) begin
          m_hv = 1;
          if (m_pend != 0) begin
            m_hc = 2; m_hlen = m_plen; m_zlp = (m_plen == 0);
          end else if (m_wr != 0) nnak = 1;
        end
        if (fw_clr_setup && m_fs != 0) begin nfs = 0; nir = 1; end
        if (fw_clr_out && !(tok_out && !tok_setup && m_fs == 0 && m_fo == 0)) nfo = 0;
        if (fw_clr_nakin && nnak == m_nak) nnak = 0;
        if (!tok_out && tok_in && m_pend != 0) begin
          npend = 0; nir = 1;
        end else if (fw_clr_inrdy && m_ir != 0) begin
          cnt = fw_byte_cnt;
          npend = 1; nplen = (cnt > MAX_PKT) ? MAX_PKT : cnt; nir = 0;
        end
      end
      m_fs = nfs; m_fo = nfo; m_ir = nir; m_nak = nnak; m_wr = nwr; m_pend = npend; m_plen = nplen;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // R12: every-cycle comparison against the model
  always @(negedge clk) if (!rst) begin
    chk("R12 hs_valid", hs_valid, m_hv);
    chk("R1/R6 hs_code", hs_code, m_hc);
    chk("R9 hs_zlp", hs_zlp, m_zlp);
    chk("R5 hs_len", hs_len, m_hlen);
    chk("R2/R3 flag_setup", flag_setup, m_fs);
    chk("R4 flag_out", flag_out, m_fo);
    chk("R5 flag_inrdy", flag_inrdy, m_ir);
    chk("R7 flag_nakin", flag_nakin, m_nak);
    chk("R6 bank_busy", bank_busy, (m_fs | m_fo | m_pend) != 0);
    chk("R10 fifo_ctl", fifo_ctl, 0);
  end

  task automatic cyc(bit s, bit d, bit o, bit i, bit cs, bit co, bit ci, bit cn, int cnt);
    tok_setup = s; setup_dir_in = d; tok_out = o; tok_in = i;
    fw_clr_setup = cs; fw_clr_out = co; fw_clr_inrdy = ci; fw_clr_nakin = cn;
    fw_byte_cnt = LEN_W'(cnt);
    @(negedge clk); #1;
    tok_setup = 0; setup_dir_in = 0; tok_out = 0; tok_in = 0;
    fw_clr_setup = 0; fw_clr_out = 0; fw_clr_inrdy = 0; fw_clr_nakin = 0; fw_byte_cnt = '0;
  endtask

  bit done = 0;
  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0; #1;
    chk("R12 reset flag_setup", flag_setup, 0);
    chk("R12 reset flag_inrdy", flag_inrdy, 0);
    chk("R10 fifo zero", fifo_ctl, 0);
    // control write: SETUP, OUT data, status ZLP
    cyc(1,0,0,0, 0,0,0,0, 0);
    chk("R1 setup ack", hs_code, 1);
    chk("R2 setup flag", flag_setup, 1);
    chk("R2 no out flag", flag_out, 0);
    cyc(0,0,1,0, 0,0,0,0, 0);
    chk("R6 out nak while setup held", hs_code, 0);
    chk("R6 out flag unchanged", flag_out, 0);
    cyc(0,0,0,0, 1,0,0,0, 0);
    chk("R3 setup cleared", flag_setup, 0);
    chk("R3 inrdy set", flag_inrdy, 1);
    cyc(0,0,1,0, 0,0,0,0, 0);
    chk("R4 out ack", hs_code, 1);
    chk("R4 out flag", flag_out, 1);
    cyc(0,0,1,0, 0,0,0,0, 0);
    chk("R6 second out nak", hs_code, 0);
    cyc(0,0,0,0, 0,1,0,0, 0);
    chk("R4 out freed", flag_out, 0);
    cyc(0,0,0,1, 0,0,0,0, 0);
    chk("R7 in nak", hs_code, 0);
    chk("R7 nakin set", flag_nakin, 1);
    cyc(0,0,0,0, 0,0,1,1, 0);
    chk("R7 nakin cleared", flag_nakin, 0);
    chk("R5 armed drops inrdy", flag_inrdy, 0);
    cyc(0,0,0,1, 0,0,0,0, 0);
    chk("R9 zlp data", hs_code, 2);
    chk("R9 zlp flag", hs_zlp, 1);
    chk("R5 inrdy back", flag_inrdy, 1);
    // control read with clamping
    cyc(1,1,0,0, 0,0,0,0, 0);
    cyc(0,0,0,0, 1,0,0,0, 0);
    cyc(0,0,0,1, 0,0,0,0, 0);
    chk("R7 read no nakin", flag_nakin, 0);
    cyc(0,0,0,0, 0,0,1,0, 100);
    cyc(0,0,0,1, 0,0,0,0, 0);
    chk("R5 clamped len", hs_len, MAX_PKT);
    chk("R9 non-zero zlp low", hs_zlp, 0);
    cyc(0,0,0,0, 0,0,1,0, 8);
    cyc(0,0,0,0, 0,0,1,0, 3);
    cyc(0,0,0,1, 0,0,0,0, 0);
    chk("R5 second clear ignored", hs_len, 8);
    // abort and priority
    cyc(0,0,0,0, 0,0,1,0, 5);
    cyc(1,0,1,1, 0,0,0,0, 0);
    chk("R11 setup wins", hs_code, 1);
    chk("R8 abort inrdy", flag_inrdy, 0);
    chk("R8 abort busy", bank_busy, 1);
    chk("R11 out ignored", flag_out, 0);
    cyc(0,0,0,1, 0,0,0,0, 0);
    chk("R8 no stale packet", hs_code, 0);
    for (int k = 0; k < 4000; k++) begin
      int r = $urandom;
      cyc(r[4:0] == 0, r[5], r[8:6] == 0, r[11:9] == 0, r[14:12] == 0,
          r[17:15] == 0, r[20:18] == 0, r[23:21] == 0, int'(r[31:24] & 8'h7f));
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule